// File: doc/BRIEF.md
# Seeded Muon Track Finder for One Tower

This block searches one detector tower for straight muon tracks that point back at the interaction region. Each crossing, it takes five hit bitmaps of logical pads, one per muon station, laid out as rows by columns. The layout is projective: pad (row, column) in the seed station lines up with pad (row, column) in stations 2, 4 and 5. Every hit pad in station 3 starts its own tracking unit, and all units run side by side in combinational logic.

A unit accepts a track when stations 2, 4 and 5 each hold a hit inside a field-of-interest window around the projected pad. The station 4 and 5 windows open in both column and row. The station 2 window opens in column only. The unit then picks the nearest station 2 hit. It extends the line through the station 3 and station 2 pads into station 1 and picks the nearest station 1 hit. The column offset between the station 1 and station 2 points gives a transverse-momentum code. A selector keeps the two candidates with the highest codes. Its result is registered once per crossing.

Window half-widths arrive on input ports, so each station can be tuned without rebuilding the block.

Top module: `mtf_track_finder`

## Requirements
- R1: A candidate is reported only for a seed whose station 3 bit is set. Pad index = row*NCOL + column, with NCOL = 8 and NROW = 2 by default. With no station 3 hit, both valid outputs are 0.
- R2: The station 2 window covers only the seed's own row, over columns within ±`win_x2` of the seed column. A hit in another row never satisfies it.
- R3: Station 4 needs a hit with row within ±`win_y4` and column within ±`win_x4` of the seed. Station 5 does the same with `win_y5` and `win_x5`. Without both, no track is formed.
- R4: Of the station 2 hits in the window, the one nearest the seed column is chosen. At equal distance, the lower column wins. Its column appears on `c0_m2`.
- R5: The station 1 projection is column 2*x2 − x3, in the seed row. The nearest hit within ±`win_x1` is chosen, with the lower column winning at equal distance. Its column appears on `c0_m1`. If no station 1 hit is found, the track is still valid, with pt code 0 and `c0_m1` = 0.
- R6: With a station 1 hit, pt code = max(1, 15 − 2·|x2 − x1|) for PT_W = 4 and PT_STEP = 2.
- R7: Candidate 0 is the track with the highest pt code. At equal codes, the lower seed index wins.
- R8: Candidate 1 is the best of the remaining tracks, and its seed differs from candidate 0. It is invalid when fewer than two tracks exist, and never valid without candidate 0.
- R9: Outputs are registered. A result appears after the first rising edge that samples the inputs. A synchronous active-low reset clears both valid bits.
- R10: Column windows take values 0..3 and row windows take 0..1. Widening a window admits hits that a narrower one rejects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hit_m1 | input | 16 | Station 1 pad hits |
| hit_m2 | input | 16 | Station 2 pad hits |
| hit_m3 | input | 16 | Station 3 (seed) pad hits |
| hit_m4 | input | 16 | Station 4 pad hits |
| hit_m5 | input | 16 | Station 5 pad hits |
| win_x1 | input | 2 | Station 1 column half-width |
| win_x2 | input | 2 | Station 2 column half-width |
| win_x4 | input | 2 | Station 4 column half-width |
| win_x5 | input | 2 | Station 5 column half-width |
| win_y4 | input | 1 | Station 4 row half-width |
| win_y5 | input | 1 | Station 5 row half-width |
| c0_valid | output | 1 | Best candidate present |
| c0_pt | output | 4 | Best candidate pt code |
| c0_seed | output | 4 | Best candidate seed pad index |
| c0_m1 | output | 3 | Best candidate station 1 column |
| c0_m2 | output | 3 | Best candidate station 2 column |
| c1_valid | output | 1 | Second candidate present |
| c1_pt | output | 4 | Second candidate pt code |
| c1_seed | output | 4 | Second candidate seed pad index |

## Verification
The patterns used are:
- a straight track, to check the basic accept path;
- a track missing station 5, to check that one absent station vetoes it;
- two tracks with different bends, to check the ordering between candidates;
- two identical tracks, to check the tie rule on seed index;
- equidistant station 2 hits, paired with a station 1 decoy that would only match the wrong pick;
- a track with no station 1 hit, to check the pt-code-0 case.

Directed cases then widen and narrow each window by one step. Each one shows that a hit just outside the window is rejected and that the same hit inside it is accepted. A station 2 hit in the wrong row confirms that station 2 has no row window. A check one cycle early confirms the register stage.

// File: rtl/mtf_pkg.sv
`timescale 1ns/1ps
// mtf_pkg: small integer helpers shared by the track finder modules.
// Assumes callers pass plain int values; no state lives here.
package mtf_pkg;

    // Absolute distance between two integer positions.
    function automatic int mtf_dist(input int a, input int b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    // pt code from the station 1 to station 2 column offset, floor of 1.
    function automatic int mtf_pt_code(input int offset, input int pt_max, input int step);
        int v;
        v = pt_max - step * offset;
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/mtf_seed_unit.sv
`timescale 1ns/1ps
// mtf_seed_unit: tracking logic for one station 3 seed pad at (ROW, COL).
// Checks the station 2, 4 and 5 windows, picks the nearest station 2 hit,
// projects the line into station 1 and picks the nearest hit there.
// Assumes a projective layout: the same (row, column) in every station.
// Purely combinational.
module mtf_seed_unit
    import mtf_pkg::*;
#(
    parameter int NROW    = 2,
    parameter int NCOL    = 8,
    parameter int WX_W    = 2,
    parameter int WY_W    = 1,
    parameter int PT_W    = 4,
    parameter int PT_STEP = 2,
    parameter int ROW     = 0,
    parameter int COL     = 0,
    localparam int NPAD   = NROW * NCOL,
    localparam int COL_W  = $clog2(NCOL)
) (
    input  logic [NPAD-1:0]  m1,
    input  logic [NPAD-1:0]  m2,
    input  logic [NPAD-1:0]  m3,
    input  logic [NPAD-1:0]  m4,
    input  logic [NPAD-1:0]  m5,
    input  logic [WX_W-1:0]  wx1,
    input  logic [WX_W-1:0]  wx2,
    input  logic [WX_W-1:0]  wx4,
    input  logic [WX_W-1:0]  wx5,
    input  logic [WY_W-1:0]  wy4,
    input  logic [WY_W-1:0]  wy5,
    output logic             trk,
    output logic [PT_W-1:0]  pt,
    output logic [COL_W-1:0] x1,
    output logic [COL_W-1:0] x2
);
    localparam int FMAX   = (1 << WX_W) - 1;
    localparam int PT_MAX = (1 << PT_W) - 1;
    localparam int SEED   = ROW * NCOL + COL;

    // True when any pad of map lies in the row/column box around the seed.
    function automatic logic box_hit(input logic [NPAD-1:0] map, input int wx, input int wy);
        logic f;
        f = 1'b0;
        for (int r = 0; r < NROW; r++) begin
            for (int c = 0; c < NCOL; c++) begin
                if (mtf_dist(r, ROW) <= wy && mtf_dist(c, COL) <= wx && map[r*NCOL + c])
                    f = 1'b1;
            end
        end
        return f;
    endfunction

    // Nearest hit in the seed row around centre, lower column first on ties.
    function automatic logic row_nearest(input logic [NPAD-1:0] map, input int centre,
                                         input int w, output int col);
        logic f;
        f   = 1'b0;
        col = 0;
        for (int d = 0; d <= FMAX; d++) begin
            if (!f && d <= w) begin
                if (centre - d >= 0 && centre - d < NCOL && map[ROW*NCOL + centre - d]) begin
                    f   = 1'b1;
                    col = centre - d;
                end else if (d != 0 && centre + d >= 0 && centre + d < NCOL &&
                             map[ROW*NCOL + centre + d]) begin
                    f   = 1'b1;
                    col = centre + d;
                end
            end
        end
        return f;
    endfunction

    logic s1_ok, s2_ok, s4_ok, s5_ok;
    int   c1, c2, code;

    // Window search across all stations for this seed.
    always_comb begin
        s2_ok = row_nearest(m2, COL, int'(wx2), c2);
        s4_ok = box_hit(m4, int'(wx4), int'(wy4));
        s5_ok = box_hit(m5, int'(wx5), int'(wy5));
        s1_ok = row_nearest(m1, 2 * c2 - COL, int'(wx1), c1);
        code  = mtf_pt_code(mtf_dist(c2, c1), PT_MAX, PT_STEP);
    end

    // Candidate fields, zeroed when no track exists.
    always_comb begin
        trk = m3[SEED] && s2_ok && s4_ok && s5_ok;
        pt  = '0;
        x1  = '0;
        x2  = '0;
        if (trk) begin
            x2 = c2[COL_W-1:0];
            if (s1_ok) begin
                x1 = c1[COL_W-1:0];
                pt = code[PT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/mtf_best_two.sv
`timescale 1ns/1ps
// mtf_best_two: picks the two tracks with the highest pt code.
// The lower seed index wins ties. The second pick excludes the first.
// Purely combinational.
module mtf_best_two #(
    parameter int NPAD   = 16,
    parameter int PT_W   = 4,
    parameter int COL_W  = 3,
    localparam int SEED_W = $clog2(NPAD)
) (
    input  logic [NPAD-1:0]             trk,
    input  logic [NPAD-1:0][PT_W-1:0]   pt_all,
    input  logic [NPAD-1:0][COL_W-1:0]  x1_all,
    input  logic [NPAD-1:0][COL_W-1:0]  x2_all,
    output logic                        b_valid,
    output logic [PT_W-1:0]             b_pt,
    output logic [SEED_W-1:0]           b_seed,
    output logic [COL_W-1:0]            b_x1,
    output logic [COL_W-1:0]            b_x2,
    output logic                        n_valid,
    output logic [PT_W-1:0]             n_pt,
    output logic [SEED_W-1:0]           n_seed
);
    int b_idx, n_idx;

    // First pass: strict greater-than keeps the lowest index among equals.
    always_comb begin
        b_valid = 1'b0;
        b_idx   = 0;
        for (int i = 0; i < NPAD; i++) begin
            if (trk[i] && (!b_valid || pt_all[i] > pt_all[b_idx])) begin
                b_valid = 1'b1;
                b_idx   = i;
            end
        end
    end

    // Second pass: same rule with the winner removed.
    always_comb begin
        n_valid = 1'b0;
        n_idx   = 0;
        for (int i = 0; i < NPAD; i++) begin
            if (trk[i] && i != b_idx && (!n_valid || pt_all[i] > pt_all[n_idx])) begin
                n_valid = 1'b1;
                n_idx   = i;
            end
        end
    end

    // Field extraction for both picks.
    always_comb begin
        b_seed = b_idx[SEED_W-1:0];
        b_pt   = b_valid ? pt_all[b_idx] : '0;
        b_x1   = b_valid ? x1_all[b_idx] : '0;
        b_x2   = b_valid ? x2_all[b_idx] : '0;
        n_seed = n_idx[SEED_W-1:0];
        n_pt   = n_valid ? pt_all[n_idx] : '0;
    end
endmodule

// File: rtl/mtf_track_finder.sv
`timescale 1ns/1ps
// mtf_track_finder: one tower of seeded muon track finding.
// It has one seed unit per pad, a best-two selector and an output register.
// Assumes the hit maps and windows are stable for the whole crossing.
// Reset is synchronous and active low.
module mtf_track_finder #(
    parameter int NROW    = 2,
    parameter int NCOL    = 8,
    parameter int WX_W    = 2,
    parameter int WY_W    = 1,
    parameter int PT_W    = 4,
    parameter int PT_STEP = 2,
    localparam int NPAD   = NROW * NCOL,
    localparam int SEED_W = $clog2(NPAD),
    localparam int COL_W  = $clog2(NCOL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPAD-1:0]   hit_m1,
    input  logic [NPAD-1:0]   hit_m2,
    input  logic [NPAD-1:0]   hit_m3,
    input  logic [NPAD-1:0]   hit_m4,
    input  logic [NPAD-1:0]   hit_m5,
    input  logic [WX_W-1:0]   win_x1,
    input  logic [WX_W-1:0]   win_x2,
    input  logic [WX_W-1:0]   win_x4,
    input  logic [WX_W-1:0]   win_x5,
    input  logic [WY_W-1:0]   win_y4,
    input  logic [WY_W-1:0]   win_y5,
    output logic              c0_valid,
    output logic [PT_W-1:0]   c0_pt,
    output logic [SEED_W-1:0] c0_seed,
    output logic [COL_W-1:0]  c0_m1,
    output logic [COL_W-1:0]  c0_m2,
    output logic              c1_valid,
    output logic [PT_W-1:0]   c1_pt,
    output logic [SEED_W-1:0] c1_seed
);
    logic [NPAD-1:0]            trk;
    logic [NPAD-1:0][PT_W-1:0]  pt_all;
    logic [NPAD-1:0][COL_W-1:0] x1_all;
    logic [NPAD-1:0][COL_W-1:0] x2_all;

    for (genvar r = 0; r < NROW; r++) begin : g_row
        for (genvar c = 0; c < NCOL; c++) begin : g_col
            mtf_seed_unit #(
                .NROW(NROW), .NCOL(NCOL), .WX_W(WX_W), .WY_W(WY_W),
                .PT_W(PT_W), .PT_STEP(PT_STEP), .ROW(r), .COL(c)
            ) u_seed (
                .m1(hit_m1), .m2(hit_m2), .m3(hit_m3), .m4(hit_m4), .m5(hit_m5),
                .wx1(win_x1), .wx2(win_x2), .wx4(win_x4), .wx5(win_x5),
                .wy4(win_y4), .wy5(win_y5),
                .trk(trk[r*NCOL + c]), .pt(pt_all[r*NCOL + c]),
                .x1(x1_all[r*NCOL + c]), .x2(x2_all[r*NCOL + c])
            );
        end
    end

    logic              b_valid, n_valid;
    logic [PT_W-1:0]   b_pt, n_pt;
    logic [SEED_W-1:0] b_seed, n_seed;
    logic [COL_W-1:0]  b_x1, b_x2;

    mtf_best_two #(.NPAD(NPAD), .PT_W(PT_W), .COL_W(COL_W)) u_sel (
        .trk(trk), .pt_all(pt_all), .x1_all(x1_all), .x2_all(x2_all),
        .b_valid(b_valid), .b_pt(b_pt), .b_seed(b_seed), .b_x1(b_x1), .b_x2(b_x2),
        .n_valid(n_valid), .n_pt(n_pt), .n_seed(n_seed)
    );

    // Register the two candidates once per crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c0_valid <= 1'b0;
            c0_pt    <= '0;
            c0_seed  <= '0;
            c0_m1    <= '0;
            c0_m2    <= '0;
            c1_valid <= 1'b0;
            c1_pt    <= '0;
            c1_seed  <= '0;
        end else begin
            c0_valid <= b_valid;
            c0_pt    <= b_pt;
            c0_seed  <= b_seed;
            c0_m1    <= b_x1;
            c0_m2    <= b_x2;
            c1_valid <= n_valid;
            c1_pt    <= n_pt;
            c1_seed  <= n_seed;
        end
    end
endmodule

// File: rtl/mtf_checker.sv
`timescale 1ns/1ps
// mtf_checker: temporal properties of the track finder outputs.
// Keeps a registered copy of the seed map so that it can relate each output
// to the crossing that produced it.
module mtf_checker #(
    parameter int NPAD   = 16,
    parameter int PT_W   = 4,
    parameter int COL_W  = 3,
    localparam int SEED_W = $clog2(NPAD)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NPAD-1:0]   hit_m3,
    input logic              c0_valid,
    input logic [PT_W-1:0]   c0_pt,
    input logic [SEED_W-1:0] c0_seed,
    input logic [COL_W-1:0]  c0_m1,
    input logic              c1_valid,
    input logic [PT_W-1:0]   c1_pt,
    input logic [SEED_W-1:0] c1_seed
);
    logic [NPAD-1:0] m3_q;

    // Seed map of the crossing that the outputs currently describe.
    always_ff @(posedge clk) begin
        if (!rst_n) m3_q <= '0;
        else        m3_q <= hit_m3;
    end

    assert_seed_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        c0_valid |-> m3_q[c0_seed]);
    assert_no_seed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (m3_q == '0) |-> (!c0_valid && !c1_valid));
    assert_no_m1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_valid && c0_pt == '0) |-> (c0_m1 == '0));
    assert_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        c1_valid |-> (c1_pt <= c0_pt));
    assert_needs_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        c1_valid |-> c0_valid);
    assert_distinct_R8: assert property (@(posedge clk) disable iff (!rst_n)
        c1_valid |-> (c1_seed != c0_seed));
endmodule

bind mtf_track_finder mtf_checker #(.NPAD(NROW*NCOL), .PT_W(PT_W), .COL_W($clog2(NCOL))) u_chk (
    .clk(clk), .rst_n(rst_n), .hit_m3(hit_m3),
    .c0_valid(c0_valid), .c0_pt(c0_pt), .c0_seed(c0_seed), .c0_m1(c0_m1),
    .c1_valid(c1_valid), .c1_pt(c1_pt), .c1_seed(c1_seed)
);

// File: tb/sim_mtf_track_finder.sv
`timescale 1ns/1ps
// sim_mtf_track_finder: table-driven checks, then directed window and reset cases.
module sim_mtf_track_finder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] m1 = '0, m2 = '0, m3 = '0, m4 = '0, m5 = '0;
    logic [1:0]  wx1 = 2'd2, wx2 = 2'd1, wx4 = 2'd1, wx5 = 2'd1;
    logic        wy4 = 1'b1, wy5 = 1'b1;
    logic        c0_valid, c1_valid;
    logic [3:0]  c0_pt, c0_seed, c1_pt, c1_seed;
    logic [2:0]  c0_m1, c0_m2;
    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    mtf_track_finder u0 (
        .clk(clk), .rst_n(rst_n),
        .hit_m1(m1), .hit_m2(m2), .hit_m3(m3), .hit_m4(m4), .hit_m5(m5),
        .win_x1(wx1), .win_x2(wx2), .win_x4(wx4), .win_x5(wx5),
        .win_y4(wy4), .win_y5(wy5),
        .c0_valid(c0_valid), .c0_pt(c0_pt), .c0_seed(c0_seed), .c0_m1(c0_m1), .c0_m2(c0_m2),
        .c1_valid(c1_valid), .c1_pt(c1_pt), .c1_seed(c1_seed)
    );

    typedef struct packed {
        logic [15:0] h1, h2, h3, h4, h5;
        logic        v0;
        logic [3:0]  p0, s0;
        logic [2:0]  x1, x2;
        logic        v1;
        logic [3:0]  p1, s1;
    } vec_t;

    // Windows for the table: x1=2, x2=1, x4=1, x5=1, y4=1, y5=1.
    localparam vec_t VECS [7] = '{
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd0,  4'd0,  3'd0, 3'd0, 1'b0, 4'd0,  4'd0}, // R1 empty
        '{16'h0008, 16'h0008, 16'h0008, 16'h0008, 16'h0008, 1'b1, 4'd15, 4'd3,  3'd3, 3'd3, 1'b0, 4'd0,  4'd0}, // R6 straight
        '{16'h0008, 16'h0008, 16'h0008, 16'h0008, 16'h0000, 1'b0, 4'd0,  4'd0,  3'd0, 3'd0, 1'b0, 4'd0,  4'd0}, // R3 no m5
        '{16'h2010, 16'h2008, 16'h2004, 16'h2004, 16'h2004, 1'b1, 4'd15, 4'd13, 3'd5, 3'd5, 1'b1, 4'd13, 4'd2}, // R7 two tracks
        '{16'h0044, 16'h0028, 16'h0010, 16'h0010, 16'h0010, 1'b1, 4'd13, 4'd4,  3'd2, 3'd3, 1'b0, 4'd0,  4'd0}, // R4 tie in m2
        '{16'h0202, 16'h0202, 16'h0202, 16'h0202, 16'h0202, 1'b1, 4'd15, 4'd1,  3'd1, 3'd1, 1'b1, 4'd15, 4'd9}, // R8 pt tie
        '{16'h0000, 16'h0040, 16'h0040, 16'h0040, 16'h0040, 1'b1, 4'd0,  4'd6,  3'd0, 3'd6, 1'b0, 4'd0,  4'd0}  // R5 no m1
    };

    // Compare one value and log a failure.
    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive maps at a falling edge, then wait until the registered result is visible.
    task automatic apply(input logic [15:0] a1, a2, a3, a4, a5);
        m1 = a1; m2 = a2; m3 = a3; m4 = a4; m5 = a5;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R9: reset clears outputs even with a track present.
        @(negedge clk);
        apply(16'h0008, 16'h0008, 16'h0008, 16'h0008, 16'h0008);
        chk("R9 reset c0_valid", c0_valid, 0);
        chk("R9 reset c1_valid", c1_valid, 0);
        rst_n = 1'b1;

        // R9: one register stage, the old result holds before the edge.
        apply(16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
        m1 = 16'h0008; m2 = 16'h0008; m3 = 16'h0008; m4 = 16'h0008; m5 = 16'h0008;
        #1 chk("R9 before edge", c0_valid, 0);
        @(posedge clk); @(negedge clk);
        chk("R9 after edge", c0_valid, 1);

        for (int i = 0; i < 7; i++) begin
            apply(VECS[i].h1, VECS[i].h2, VECS[i].h3, VECS[i].h4, VECS[i].h5);
            chk($sformatf("R1/R7 vec%0d c0_valid", i), c0_valid, VECS[i].v0);
            chk($sformatf("R8 vec%0d c1_valid", i), c1_valid, VECS[i].v1);
            if (VECS[i].v0) begin
                chk($sformatf("R6 vec%0d c0_pt", i), c0_pt, VECS[i].p0);
                chk($sformatf("R7 vec%0d c0_seed", i), c0_seed, VECS[i].s0);
                chk($sformatf("R5 vec%0d c0_m1", i), c0_m1, VECS[i].x1);
                chk($sformatf("R4 vec%0d c0_m2", i), c0_m2, VECS[i].x2);
            end
            if (VECS[i].v1) begin
                chk($sformatf("R8 vec%0d c1_pt", i), c1_pt, VECS[i].p1);
                chk($sformatf("R8 vec%0d c1_seed", i), c1_seed, VECS[i].s1);
            end
        end

        // R10 and R2: station 2 hit two columns away from seed column 3.
        wx1 = 2'd0; wx2 = 2'd1;
        apply(16'h0080, 16'h0020, 16'h0008, 16'h0008, 16'h0008);
        chk("R10 narrow x2 rejects", c0_valid, 0);
        wx2 = 2'd2;
        apply(16'h0080, 16'h0020, 16'h0008, 16'h0008, 16'h0008);
        chk("R10 wide x2 accepts", c0_valid, 1);
        chk("R6 bend pt", c0_pt, 11);
        chk("R5 projected m1", c0_m1, 7);
        chk("R4 m2 col", c0_m2, 5);

        // R3: station 4 hit one row off.
        wx1 = 2'd1; wx2 = 2'd1; wy4 = 1'b0;
        apply(16'h0008, 16'h0008, 16'h0008, 16'h0800, 16'h0008);
        chk("R3 y4=0 rejects", c0_valid, 0);
        wy4 = 1'b1;
        apply(16'h0008, 16'h0008, 16'h0008, 16'h0800, 16'h0008);
        chk("R3 y4=1 accepts", c0_valid, 1);
        chk("R3 pt", c0_pt, 15);

        // R2: station 2 has no row window.
        wx2 = 2'd3;
        apply(16'h0008, 16'h0800, 16'h0008, 16'h0008, 16'h0008);
        chk("R2 other row ignored", c0_valid, 0);
        chk("R2 c1 none", c1_valid, 0);

        // R5: station 1 window width.
        wx2 = 2'd1; wx1 = 2'd1;
        apply(16'h0020, 16'h0008, 16'h0008, 16'h0008, 16'h0008);
        chk("R5 m1 outside valid", c0_valid, 1);
        chk("R5 m1 outside pt", c0_pt, 0);
        chk("R5 m1 outside col", c0_m1, 0);
        wx1 = 2'd2;
        apply(16'h0020, 16'h0008, 16'h0008, 16'h0008, 16'h0008);
        chk("R5 m1 inside pt", c0_pt, 11);
        chk("R5 m1 inside col", c0_m1, 5);

        // R9: reset mid-run clears valid.
        rst_n = 1'b0;
        apply(16'h0008, 16'h0008, 16'h0008, 16'h0008, 16'h0008);
        chk("R9 mid reset", c0_valid, 0);

        summary();
    end
endmodule